// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block computes the next program counter for an 8-bit core whose program counter counts instruction words. On each valid request it takes the current PC, a decoded control-flow kind, a signed relative offset, the 16-bit indirect target register, the status byte, a bit index, two operand bytes for compare-and-skip, and a flag saying whether the following instruction is one or two words long. One cycle later it presents the next PC, whether control flow was redirected, and how many cycles the instruction costs.

It handles unconditional relative jumps, indirect jumps, conditional branches on any status bit, signed greater-or-equal and less-than branches, and skip-next-instruction tests. All PC arithmetic wraps within a program memory of 2^PC_W words. The fetch stage feeds `npc_o` back as its next address. It stalls for `cycles_o` cycles.

The status byte uses fixed bit positions, because the neighbouring decoder relies on them: carry in bit 0, zero in bit 1, negative in bit 2 and overflow in bit 3.

Top module: `branch_npc_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o`, `npc_o` and `cycles_o` are all zero.
- R2: `valid_o` is high exactly one cycle after a cycle with `valid_i` high, and low otherwise. The other outputs belong to that request.
- R3: Kind 1 (relative jump) gives `npc_o` = PC + sext12(offset[11:0]) + 1, with taken = 1 and 2 cycles.
- R4: Kind 2 (indirect jump) gives `npc_o` = the low PC_W bits of `z_i`, with taken = 1 and 2 cycles.
- R5: Kind 3 is taken when `sreg_i[bit_sel_i]` is 1, and kind 4 is taken when it is 0. A taken branch gives PC + sext7(offset[6:0]) + 1 and 2 cycles, and offset bits 11:7 are ignored. A branch that is not taken gives PC + 1 and 1 cycle.
- R6: Kind 5 (signed greater-or-equal) is taken when N xor V is 0. Kind 6 (signed less-than) is taken when N xor V is 1. N is status bit 2 and V is status bit 3. Target and cost follow R5.
- R7: Kind 7 (compare-skip) skips when `op_a_i` equals `op_b_i`.
- R8: Kind 8 skips when `op_a_i[bit_sel_i]` is 0. Kind 9 skips when `op_a_i[bit_sel_i]` is 1.
- R9: A skip whose condition holds gives PC + 2 and 2 cycles when `next_two_word_i` is 0. It gives PC + 3 and 3 cycles when `next_two_word_i` is 1. Either way taken = 1. A skip whose condition fails gives PC + 1, 1 cycle and taken = 0.
- R10: Every next-PC result wraps modulo 2^PC_W.
- R11: Kind 0 (sequential), and any kind code above 9, gives PC + 1 with taken = 0 and 1 cycle.
- R12: On every valid result, taken implies a cost of 2 or 3 cycles, and not taken implies a cost of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 4 | Control-flow kind code (R3 to R11) |
| pc_i | input | PC_W | Current word address |
| offset_i | input | 12 | Signed relative offset field |
| z_i | input | 16 | Indirect target register pair |
| sreg_i | input | 8 | Status byte |
| bit_sel_i | input | 3 | Bit index for status or operand tests |
| op_a_i | input | 8 | First operand for skips |
| op_b_i | input | 8 | Second operand for compare-skip |
| next_two_word_i | input | 1 | Following instruction is two words long |
| valid_o | output | 1 | Result present |
| npc_o | output | PC_W | Next word address |
| taken_o | output | 1 | Control flow redirected |
| cycles_o | output | 2 | Cycle cost of the instruction |

## Verification
The bench builds the unit with PC_W = 10, a 1024-word program space. This puts wrap-around within reach of short offsets at both ends: a backward jump from address 2 lands on 0x3FF, and both a forward jump and a three-word skip from 0x3FE land just past zero. An indirect target with nonzero upper bits shows the truncation to PC_W bits. A branch offset with set upper bits shows that only the 7-bit field is used.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int REL_LONG_W  = 12;
  localparam int REL_SHORT_W = 7;
  localparam int ZREG_W      = 16;
  localparam int DATA_W      = 8;
  localparam int BSEL_W      = 3;
  localparam int CYC_W       = 2;

  // status bit positions decoded by the neighbouring ALU
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_N = 2;
  localparam int SB_V = 3;

  typedef enum logic [3:0] {
    K_SEQ    = 4'd0,
    K_RJMP   = 4'd1,
    K_IJMP   = 4'd2,
    K_BR_SET = 4'd3,
    K_BR_CLR = 4'd4,
    K_BR_GE  = 4'd5,
    K_BR_LT  = 4'd6,
    K_SK_EQ  = 4'd7,
    K_SK_BC  = 4'd8,
    K_SK_BS  = 4'd9
  } flow_kind_e;

  function automatic logic is_branch(input flow_kind_e k);
    return (k == K_BR_SET) || (k == K_BR_CLR) || (k == K_BR_GE) || (k == K_BR_LT);
  endfunction

  function automatic logic is_skip(input flow_kind_e k);
    return (k == K_SK_EQ) || (k == K_SK_BC) || (k == K_SK_BS);
  endfunction
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
(
  input  flow_kind_e          kind_i,
  input  logic [DATA_W-1:0]   sreg_i,
  input  logic [BSEL_W-1:0]   bit_sel_i,
  input  logic [DATA_W-1:0]   op_a_i,
  input  logic [DATA_W-1:0]   op_b_i,
  output logic                taken_o
);
  logic sign_lt;
  assign sign_lt = sreg_i[SB_N] ^ sreg_i[SB_V];

  always_comb begin
    unique case (kind_i)
      K_RJMP, K_IJMP: taken_o = 1'b1;
      K_BR_SET:       taken_o = sreg_i[bit_sel_i];
      K_BR_CLR:       taken_o = ~sreg_i[bit_sel_i];
      K_BR_GE:        taken_o = ~sign_lt;
      K_BR_LT:        taken_o = sign_lt;
      K_SK_EQ:        taken_o = (op_a_i == op_b_i);
      K_SK_BC:        taken_o = ~op_a_i[bit_sel_i];
      K_SK_BS:        taken_o = op_a_i[bit_sel_i];
      default:        taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  flow_kind_e            kind_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [REL_LONG_W-1:0] offset_i,
  input  logic [ZREG_W-1:0]     z_i,
  input  logic                  next_two_word_i,
  input  logic                  taken_i,
  output logic [PC_W-1:0]       npc_o
);
  logic [ZREG_W-1:0] off_short_x, off_long_x;
  logic [PC_W-1:0]   pc_seq, pc_rel_short, pc_rel_long, pc_skip, pc_ind;

  assign off_short_x = {{(ZREG_W-REL_SHORT_W){offset_i[REL_SHORT_W-1]}},
                        offset_i[REL_SHORT_W-1:0]};
  assign off_long_x  = {{(ZREG_W-REL_LONG_W){offset_i[REL_LONG_W-1]}}, offset_i};

  // all sums truncate to PC_W bits: modulo program space
  assign pc_seq       = pc_i + PC_W'(1);
  assign pc_rel_short = pc_i + PC_W'(off_short_x) + PC_W'(1);
  assign pc_rel_long  = pc_i + PC_W'(off_long_x) + PC_W'(1);
  assign pc_skip      = pc_i + (next_two_word_i ? PC_W'(3) : PC_W'(2));
  assign pc_ind       = PC_W'(z_i);

  always_comb begin
    if (kind_i == K_RJMP)                 npc_o = pc_rel_long;
    else if (kind_i == K_IJMP)            npc_o = pc_ind;
    else if (is_branch(kind_i) && taken_i) npc_o = pc_rel_short;
    else if (is_skip(kind_i) && taken_i)   npc_o = pc_skip;
    else                                   npc_o = pc_seq;
  end
endmodule

// File: rtl/npc_cost.sv
module npc_cost
  import npc_pkg::*;
(
  input  flow_kind_e       kind_i,
  input  logic             taken_i,
  input  logic             next_two_word_i,
  output logic [CYC_W-1:0] cycles_o
);
  always_comb begin
    if (kind_i == K_RJMP || kind_i == K_IJMP)  cycles_o = 2'd2;
    else if (is_branch(kind_i) && taken_i)     cycles_o = 2'd2;
    else if (is_skip(kind_i) && taken_i)       cycles_o = next_two_word_i ? 2'd3 : 2'd2;
    else                                       cycles_o = 2'd1;
  end
endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [3:0]            kind_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [REL_LONG_W-1:0] offset_i,
  input  logic [ZREG_W-1:0]     z_i,
  input  logic [DATA_W-1:0]     sreg_i,
  input  logic [BSEL_W-1:0]     bit_sel_i,
  input  logic [DATA_W-1:0]     op_a_i,
  input  logic [DATA_W-1:0]     op_b_i,
  input  logic                  next_two_word_i,
  output logic                  valid_o,
  output logic [PC_W-1:0]       npc_o,
  output logic                  taken_o,
  output logic [CYC_W-1:0]      cycles_o
);
  flow_kind_e        kind;
  logic              taken_d;
  logic [PC_W-1:0]   npc_d;
  logic [CYC_W-1:0]  cycles_d;

  assign kind = flow_kind_e'(kind_i);

  npc_cond_eval u_cond (
    .kind_i    (kind),
    .sreg_i    (sreg_i),
    .bit_sel_i (bit_sel_i),
    .op_a_i    (op_a_i),
    .op_b_i    (op_b_i),
    .taken_o   (taken_d)
  );

  npc_target_gen #(.PC_W(PC_W)) u_target (
    .kind_i          (kind),
    .pc_i            (pc_i),
    .offset_i        (offset_i),
    .z_i             (z_i),
    .next_two_word_i (next_two_word_i),
    .taken_i         (taken_d),
    .npc_o           (npc_d)
  );

  npc_cost u_cost (
    .kind_i          (kind),
    .taken_i         (taken_d),
    .next_two_word_i (next_two_word_i),
    .cycles_o        (cycles_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      npc_o    <= '0;
      taken_o  <= 1'b0;
      cycles_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        npc_o    <= npc_d;
        taken_o  <= taken_d;
        cycles_o <= cycles_d;
      end
    end
  end
endmodule

// File: rtl/npc_unit_checks.sv
module npc_unit_checks
  import npc_pkg::*;
#(
  parameter int PC_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        kind_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [ZREG_W-1:0] z_i,
  input logic              valid_o,
  input logic [PC_W-1:0]   npc_o,
  input logic              taken_o,
  input logic [CYC_W-1:0]  cycles_o
);
  logic [PC_W-1:0] pc_inc, z_low;
  assign pc_inc = pc_i + PC_W'(1);
  assign z_low  = PC_W'(z_i);

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r4_ijmp_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 4'(K_IJMP)) |=> (npc_o == $past(z_low) && taken_o && cycles_o == 2'd2));
  a_r11_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 4'(K_SEQ)) |=> (npc_o == $past(pc_inc) && !taken_o && cycles_o == 2'd1));
  a_r12_taken_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> (cycles_o == 2'd2 || cycles_o == 2'd3));
  a_r12_not_taken_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> (cycles_o == 2'd1));
  a_r9_three_needs_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cycles_o == 2'd3) |-> taken_o);
endmodule

bind branch_npc_unit npc_unit_checks #(.PC_W(PC_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .kind_i   (kind_i),
  .pc_i     (pc_i),
  .z_i      (z_i),
  .valid_o  (valid_o),
  .npc_o    (npc_o),
  .taken_o  (taken_o),
  .cycles_o (cycles_o)
);

// File: tb/branch_npc_unit_tb_top.sv
module branch_npc_unit_tb_top;
  import npc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [3:0] kind_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [11:0] offset_i = '0;
  logic [15:0] z_i = '0;
  logic [7:0] sreg_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] op_a_i = '0;
  logic [7:0] op_b_i = '0;
  logic next_two_word_i = 1'b0;
  logic valid_o, taken_o;
  logic [PC_W-1:0] npc_o;
  logic [1:0] cycles_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [PC_W-1:0] q_npc[$];
  logic q_tk[$];
  logic [1:0] q_cy[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  branch_npc_unit #(.PC_W(PC_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .pc_i(pc_i), .offset_i(offset_i), .z_i(z_i), .sreg_i(sreg_i),
    .bit_sel_i(bit_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .next_two_word_i(next_two_word_i), .valid_o(valid_o), .npc_o(npc_o),
    .taken_o(taken_o), .cycles_o(cycles_o)
  );

  task automatic send(input logic [3:0] k, input logic [PC_W-1:0] pc, input logic [11:0] off,
                      input logic [15:0] z, input logic [7:0] sr, input logic [2:0] bs,
                      input logic [7:0] a, input logic [7:0] b, input logic two,
                      input logic [PC_W-1:0] e_npc, input logic e_tk, input logic [1:0] e_cy,
                      input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; kind_i = k; pc_i = pc; offset_i = off; z_i = z; sreg_i = sr;
    bit_sel_i = bs; op_a_i = a; op_b_i = b; next_two_word_i = two;
    q_npc.push_back(e_npc); q_tk.push_back(e_tk); q_cy.push_back(e_cy); q_tag.push_back(tag);
  endtask

  // monitor: pops one expected item per valid result
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        checks++;
        if (q_npc.size() == 0) begin
          fails++;
          $display("FAIL R2: valid_o=1 with no pending request, expected valid_o=0");
        end else begin
          logic [PC_W-1:0] e_n;
          logic e_t;
          logic [1:0] e_c;
          string t;
          e_n = q_npc.pop_front(); e_t = q_tk.pop_front();
          e_c = q_cy.pop_front(); t = q_tag.pop_front();
          if (npc_o !== e_n || taken_o !== e_t || cycles_o !== e_c) begin
            fails++;
            $display("FAIL %s: npc=%h taken=%b cycles=%0d expected npc=%h taken=%b cycles=%0d",
                     t, npc_o, taken_o, cycles_o, e_n, e_t, e_c);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    checks++;  // R1 reset state
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || npc_o !== '0 || cycles_o !== 2'd0) begin
      fails++;
      $display("FAIL R1: valid=%b taken=%b npc=%h cycles=%0d expected all zero",
               valid_o, taken_o, npc_o, cycles_o);
    end
    rst_ni = 1'b1;

    send(4'(K_SEQ),   10'h100, 12'h000, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h101, 1'b0, 2'd1, "R11 seq");
    send(4'd15,       10'h3FF, 12'h005, 16'h0, 8'hFF, 3'd0, 8'h0, 8'h0, 1'b1, 10'h000, 1'b0, 2'd1, "R11 undefined kind wrap");
    send(4'(K_RJMP),  10'h100, 12'h005, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h106, 1'b1, 2'd2, "R3 forward");
    send(4'(K_RJMP),  10'h100, 12'hFFE, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h0FF, 1'b1, 2'd2, "R3 backward");
    send(4'(K_RJMP),  10'h002, 12'hFFC, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h3FF, 1'b1, 2'd2, "R10 wrap below zero");
    send(4'(K_RJMP),  10'h3FE, 12'h003, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h002, 1'b1, 2'd2, "R10 wrap past top");
    send(4'(K_IJMP),  10'h123, 12'h000, 16'hABCD, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h3CD, 1'b1, 2'd2, "R4 indirect");
    send(4'(K_BR_SET),10'h200, 12'h03F, 16'h0, 8'h02, 3'd1, 8'h0, 8'h0, 1'b0, 10'h240, 1'b1, 2'd2, "R5 set taken");
    send(4'(K_BR_SET),10'h200, 12'h03F, 16'h0, 8'hFD, 3'd1, 8'h0, 8'h0, 1'b0, 10'h201, 1'b0, 2'd1, "R5 set not taken");
    send(4'(K_BR_CLR),10'h200, 12'hF40, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h1C1, 1'b1, 2'd2, "R5 clear taken 7-bit offset");
    send(4'(K_BR_CLR),10'h200, 12'hF40, 16'h0, 8'h01, 3'd0, 8'h0, 8'h0, 1'b0, 10'h201, 1'b0, 2'd1, "R5 clear not taken");
    send(4'(K_BR_SET),10'h010, 12'h07F, 16'h0, 8'h80, 3'd7, 8'h0, 8'h0, 1'b0, 10'h010, 1'b1, 2'd2, "R5 bit7 offset -1");
    send(4'(K_BR_GE), 10'h050, 12'h010, 16'h0, 8'h0C, 3'd0, 8'h0, 8'h0, 1'b0, 10'h061, 1'b1, 2'd2, "R6 ge taken");
    send(4'(K_BR_GE), 10'h050, 12'h010, 16'h0, 8'h04, 3'd0, 8'h0, 8'h0, 1'b0, 10'h051, 1'b0, 2'd1, "R6 ge not taken");
    send(4'(K_BR_LT), 10'h050, 12'h010, 16'h0, 8'h08, 3'd0, 8'h0, 8'h0, 1'b0, 10'h061, 1'b1, 2'd2, "R6 lt taken");
    send(4'(K_BR_LT), 10'h050, 12'h010, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 1'b0, 10'h051, 1'b0, 2'd1, "R6 lt not taken");
    send(4'(K_SK_EQ), 10'h300, 12'h0, 16'h0, 8'h00, 3'd0, 8'h5A, 8'h5A, 1'b0, 10'h302, 1'b1, 2'd2, "R7 equal one-word skip");
    send(4'(K_SK_EQ), 10'h300, 12'h0, 16'h0, 8'h00, 3'd0, 8'h5A, 8'h5B, 1'b1, 10'h301, 1'b0, 2'd1, "R7 unequal");
    send(4'(K_SK_EQ), 10'h3FE, 12'h0, 16'h0, 8'h00, 3'd0, 8'h11, 8'h11, 1'b1, 10'h001, 1'b1, 2'd3, "R9 two-word skip wrap");
    send(4'(K_SK_BC), 10'h020, 12'h0, 16'h0, 8'h00, 3'd3, 8'hF7, 8'h0, 1'b1, 10'h023, 1'b1, 2'd3, "R8 bit clear skip");
    send(4'(K_SK_BC), 10'h020, 12'h0, 16'h0, 8'h00, 3'd3, 8'h08, 8'h0, 1'b1, 10'h021, 1'b0, 2'd1, "R8 bit clear no skip");
    send(4'(K_SK_BS), 10'h020, 12'h0, 16'h0, 8'h00, 3'd3, 8'h08, 8'h0, 1'b0, 10'h022, 1'b1, 2'd2, "R8 bit set skip");
    send(4'(K_SK_BS), 10'h020, 12'h0, 16'h0, 8'h00, 3'd3, 8'hF7, 8'h0, 1'b0, 10'h021, 1'b0, 2'd1, "R8 bit set no skip");

    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    checks++;  // R2 idle and drained
    if (valid_o !== 1'b0 || q_npc.size() != 0) begin
      fails++;
      $display("FAIL R2: valid_o=%b pending=%0d expected valid_o=0 pending=0", valid_o, q_npc.size());
    end
    finish_run();
  end
endmodule